// File: doc/BRIEF.md
# Reconfigurable Slot Isolation Manager

This block is the control point between the fixed part of a chip and a set of slots whose logic can be swapped at run time. A host reaches it through an AXI-Lite slave port. Each slot has its own 4 KiB register window. From that window the block drives the slot's clock enable, its isolation control, its active-low reset, and the cache and protection attributes that go with the slot's memory-master requests.

Every slot also has an isolation stage in the block. Each AXI valid and ready line that crosses between the slot and the fixed side goes through this stage, and so do the slot's interrupts and its reset. While the slot is isolated, all of these lines are forced to a quiet value. Data and address payload wires are not routed through the block, because zero handshakes already make them harmless.

Software brings a slot up in this order: load the slot's logic, set the attributes, release the reset, then switch on the clock and remove the isolation. To take a slot down, it writes 0 to the run register. This gates the clock, isolates the slot and puts the slot back into reset in the same cycle.

Top module: `slot_iso_mgr`

## Requirements
- R1: After the synchronous active-high reset, every slot has `slot_clk_en`=0, `slot_decouple`=1, `slot_rst_n`=0, and attribute outputs of 0. Every mapped register reads 0.
- R2: The window of slot k (k = 1..NUM_SLOTS, NUM_SLOTS at most 9) begins at byte address 0x4000 + (k-1)*0x1000. Address bits [15:12] select the window and bits [11:0] select the register. Slot k drives bit k-1 of the per-slot outputs and slice k-1 of the bundled outputs.
- R3: Bit 0 of offset 0x0 is the run bit. Writing 1 sets `slot_clk_en`=1 and `slot_decouple`=0 from the clock edge that accepts the write. Writing 0 returns the slot to gated and isolated.
- R4: Bit 0 of offset 0x4 is the reset release. `slot_rst_n` is 1 only when this bit is 1 and the slot is not isolated.
- R5: Bits [3:0] of offset 0x8 drive `slot_axcache` and bits [2:0] of offset 0xC drive `slot_axprot`. Both take effect whether or not the slot is isolated.
- R6: A read of a mapped register returns the last value written, masked to its implemented width: 1, 1, 4 and 3 bits respectively. All other bits read 0.
- R7: While a slot is isolated, its slices of `hs_to_slot_o` and `hs_to_static_o` are all 0. While it is coupled, each bit equals the same bit of the matching input bundle.
- R8: While a slot is isolated, its slice of `irq_static_o` is 0. While it is coupled, the slice equals `irq_slot_i`.
- R9: The following are unmapped: addresses outside every slot window, windows above NUM_SLOTS, and offsets other than 0x0, 0x4, 0x8 and 0xC. They read 0, writes to them change no output, and they answer OKAY.
- R10: A write to one slot's window changes no output of any other slot.
- R11: A write is accepted when address and data are valid together. `csr_bvalid` rises in the next cycle and stays high until `csr_bready`. Read data arrives with `csr_rvalid` one cycle after the address is accepted. Every response is OKAY (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_awaddr | input | 16 | Write address |
| csr_awvalid | input | 1 | Write address valid |
| csr_awready | output | 1 | Write address ready |
| csr_wdata | input | 32 | Write data |
| csr_wvalid | input | 1 | Write data valid |
| csr_wready | output | 1 | Write data ready |
| csr_bresp | output | 2 | Write response |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response ready |
| csr_araddr | input | 16 | Read address |
| csr_arvalid | input | 1 | Read address valid |
| csr_arready | output | 1 | Read address ready |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data ready |
| slot_clk_en | output | NUM_SLOTS | Clock enable per slot |
| slot_decouple | output | NUM_SLOTS | Isolation active per slot |
| slot_rst_n | output | NUM_SLOTS | Active-low reset toward each slot |
| slot_axcache | output | NUM_SLOTS*4 | Cache attribute per slot |
| slot_axprot | output | NUM_SLOTS*3 | Protection attribute per slot |
| hs_to_slot_i | input | NUM_SLOTS*HS_W | Handshake lines from fixed side headed into slots |
| hs_to_slot_o | output | NUM_SLOTS*HS_W | Same lines after isolation |
| hs_to_static_i | input | NUM_SLOTS*HS_W | Handshake lines from slots headed to fixed side |
| hs_to_static_o | output | NUM_SLOTS*HS_W | Same lines after isolation |
| irq_slot_i | input | NUM_SLOTS*IRQ_W | Interrupts raised by slots |
| irq_static_o | output | NUM_SLOTS*IRQ_W | Interrupts after isolation |

## Verification
The bench first drives every handshake and interrupt input to all ones, then to a mixed pattern, so that any pass-through line that escapes isolation can be seen. The same patterns are repeated with exactly one slot coupled, which shows whether the isolation follows the slot's own run bit or leaks onto its neighbours. Register writes use all-ones data, so readback shows the width masking. A reset release is written while the slot is still isolated and checked again after the slot is isolated once more; this shows whether the reset release is correctly gated by the isolation. Reads and writes to a window above the configured slot count, to an address below the first window and to an unused offset confirm that these accesses are inert.

// File: rtl/slot_iso_pkg.sv
package slot_iso_pkg;

    localparam int MAX_SLOTS = 9;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 32;
    localparam int CACHE_W   = 4;
    localparam int PROT_W    = 3;
    localparam int PAGE_LSB  = 12;
    localparam int BASE_PAGE = 4;
    localparam int SLOT_IDX_W = 4;
    localparam int FIELD_W   = (CACHE_W > PROT_W) ? CACHE_W : PROT_W;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [1:0] {
        REG_RUN   = 2'd0,
        REG_REL   = 2'd1,
        REG_CACHE = 2'd2,
        REG_PROT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               run;
        logic               rel;
        logic [CACHE_W-1:0] cache;
        logic [PROT_W-1:0]  prot;
    } slot_ctrl_t;

    typedef struct packed {
        logic                  hit;
        logic [SLOT_IDX_W-1:0] slot;
        reg_sel_e              sel;
    } reg_dec_t;

    function automatic reg_dec_t addr_decode(input logic [ADDR_W-1:0] a,
                                             input int nslots);
        reg_dec_t d;
        int pg;
        pg       = int'(a[ADDR_W-1:PAGE_LSB]);
        d.hit    = (pg >= BASE_PAGE) && (pg < BASE_PAGE + nslots) &&
                   (a[PAGE_LSB-1:4] == '0) && (a[1:0] == 2'b00);
        d.slot   = SLOT_IDX_W'(pg - BASE_PAGE);
        d.sel    = reg_sel_e'(a[3:2]);
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_word(input slot_ctrl_t c,
                                                    input reg_sel_e s);
        logic [DATA_W-1:0] w;
        w = '0;
        case (s)
            REG_RUN:   w[0] = c.run;
            REG_REL:   w[0] = c.rel;
            REG_CACHE: w[CACHE_W-1:0] = c.cache;
            default:   w[PROT_W-1:0] = c.prot;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/slot_iso_axil.sv
module slot_iso_axil
    import slot_iso_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    output logic              wr_fire,
    output reg_dec_t          wr_dec,
    output reg_dec_t          rd_dec,
    input  logic [DATA_W-1:0] rd_word
);

    logic rd_fire;

    // Write needs both channels; one outstanding response at a time.
    assign wr_fire = awvalid && wvalid && !bvalid;
    assign awready = wr_fire;
    assign wready  = wr_fire;
    assign wr_dec  = addr_decode(awaddr, NUM_SLOTS);

    assign rd_fire = arvalid && !rvalid;
    assign arready = rd_fire;
    assign rd_dec  = addr_decode(araddr, NUM_SLOTS);

    assign bresp = RESP_OKAY;
    assign rresp = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            bvalid <= 1'b0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            if (wr_fire)
                bvalid <= 1'b1;
            else if (bready)
                bvalid <= 1'b0;

            if (rd_fire) begin
                rvalid <= 1'b1;
                rdata  <= rd_word;
            end else if (rready) begin
                rvalid <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/slot_iso_regs.sv
module slot_iso_regs
    import slot_iso_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  reg_sel_e           sel,
    input  logic [FIELD_W-1:0] wfield,
    output slot_ctrl_t         ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (we) begin
            case (sel)
                REG_RUN:   ctrl.run   <= wfield[0];
                REG_REL:   ctrl.rel   <= wfield[0];
                REG_CACHE: ctrl.cache <= wfield[CACHE_W-1:0];
                default:   ctrl.prot  <= wfield[PROT_W-1:0];
            endcase
        end
    end

endmodule

// File: rtl/slot_iso_decoupler.sv
module slot_iso_decoupler #(
    parameter int HS_W  = 10,
    parameter int IRQ_W = 4
) (
    input  logic             iso,
    input  logic             rel,
    input  logic [HS_W-1:0]  to_slot_i,
    output logic [HS_W-1:0]  to_slot_o,
    input  logic [HS_W-1:0]  to_static_i,
    output logic [HS_W-1:0]  to_static_o,
    input  logic [IRQ_W-1:0] irq_i,
    output logic [IRQ_W-1:0] irq_o,
    output logic             rst_n_o
);

    // Quiet value for every crossing line is 0; reset stays asserted.
    assign to_slot_o   = iso ? '0 : to_slot_i;
    assign to_static_o = iso ? '0 : to_static_i;
    assign irq_o       = iso ? '0 : irq_i;
    assign rst_n_o     = rel && !iso;

endmodule

// File: rtl/slot_iso_mgr.sv
module slot_iso_mgr
    import slot_iso_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int HS_W      = 10,
    parameter int IRQ_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [15:0]                 csr_awaddr,
    input  logic                        csr_awvalid,
    output logic                        csr_awready,
    input  logic [31:0]                 csr_wdata,
    input  logic                        csr_wvalid,
    output logic                        csr_wready,
    output logic [1:0]                  csr_bresp,
    output logic                        csr_bvalid,
    input  logic                        csr_bready,
    input  logic [15:0]                 csr_araddr,
    input  logic                        csr_arvalid,
    output logic                        csr_arready,
    output logic [31:0]                 csr_rdata,
    output logic [1:0]                  csr_rresp,
    output logic                        csr_rvalid,
    input  logic                        csr_rready,
    output logic [NUM_SLOTS-1:0]        slot_clk_en,
    output logic [NUM_SLOTS-1:0]        slot_decouple,
    output logic [NUM_SLOTS-1:0]        slot_rst_n,
    output logic [NUM_SLOTS*4-1:0]      slot_axcache,
    output logic [NUM_SLOTS*3-1:0]      slot_axprot,
    input  logic [NUM_SLOTS*HS_W-1:0]   hs_to_slot_i,
    output logic [NUM_SLOTS*HS_W-1:0]   hs_to_slot_o,
    input  logic [NUM_SLOTS*HS_W-1:0]   hs_to_static_i,
    output logic [NUM_SLOTS*HS_W-1:0]   hs_to_static_o,
    input  logic [NUM_SLOTS*IRQ_W-1:0]  irq_slot_i,
    output logic [NUM_SLOTS*IRQ_W-1:0]  irq_static_o
);

    localparam int SLOTS = (NUM_SLOTS > MAX_SLOTS) ? MAX_SLOTS : NUM_SLOTS;

    logic              wr_fire;
    reg_dec_t          wr_dec;
    reg_dec_t          rd_dec;
    logic [DATA_W-1:0] rd_word;
    slot_ctrl_t        ctrl [NUM_SLOTS];

    slot_iso_axil #(.NUM_SLOTS(SLOTS)) u_bus (
        .clk     (clk),
        .rst     (rst),
        .awaddr  (csr_awaddr),
        .awvalid (csr_awvalid),
        .awready (csr_awready),
        .wvalid  (csr_wvalid),
        .wready  (csr_wready),
        .bresp   (csr_bresp),
        .bvalid  (csr_bvalid),
        .bready  (csr_bready),
        .araddr  (csr_araddr),
        .arvalid (csr_arvalid),
        .arready (csr_arready),
        .rdata   (csr_rdata),
        .rresp   (csr_rresp),
        .rvalid  (csr_rvalid),
        .rready  (csr_rready),
        .wr_fire (wr_fire),
        .wr_dec  (wr_dec),
        .rd_dec  (rd_dec),
        .rd_word (rd_word)
    );

    // Read mux: only a decoded hit on an existing slot returns data.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_dec.hit && rd_dec.slot == SLOT_IDX_W'(i))
                rd_word = ctrl_word(ctrl[i], rd_dec.sel);
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic we;
        assign we = wr_fire && wr_dec.hit && (wr_dec.slot == SLOT_IDX_W'(g));

        slot_iso_regs u_regs (
            .clk    (clk),
            .rst    (rst),
            .we     (we),
            .sel    (wr_dec.sel),
            .wfield (csr_wdata[FIELD_W-1:0]),
            .ctrl   (ctrl[g])
        );

        assign slot_clk_en[g]          = ctrl[g].run;
        assign slot_decouple[g]        = !ctrl[g].run;
        assign slot_axcache[g*4 +: 4]  = ctrl[g].cache;
        assign slot_axprot[g*3 +: 3]   = ctrl[g].prot;

        slot_iso_decoupler #(.HS_W(HS_W), .IRQ_W(IRQ_W)) u_iso (
            .iso         (!ctrl[g].run),
            .rel         (ctrl[g].rel),
            .to_slot_i   (hs_to_slot_i[g*HS_W +: HS_W]),
            .to_slot_o   (hs_to_slot_o[g*HS_W +: HS_W]),
            .to_static_i (hs_to_static_i[g*HS_W +: HS_W]),
            .to_static_o (hs_to_static_o[g*HS_W +: HS_W]),
            .irq_i       (irq_slot_i[g*IRQ_W +: IRQ_W]),
            .irq_o       (irq_static_o[g*IRQ_W +: IRQ_W]),
            .rst_n_o     (slot_rst_n[g])
        );
    end

endmodule

// File: rtl/slot_iso_chk.sv
module slot_iso_chk #(
    parameter int NUM_SLOTS = 2,
    parameter int HS_W      = 10,
    parameter int IRQ_W     = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       csr_awvalid,
    input logic                       csr_wvalid,
    input logic [1:0]                 csr_bresp,
    input logic                       csr_bvalid,
    input logic                       csr_bready,
    input logic [1:0]                 csr_rresp,
    input logic                       csr_rvalid,
    input logic [NUM_SLOTS-1:0]       slot_clk_en,
    input logic [NUM_SLOTS-1:0]       slot_decouple,
    input logic [NUM_SLOTS-1:0]       slot_rst_n,
    input logic [NUM_SLOTS*HS_W-1:0]  hs_to_slot_i,
    input logic [NUM_SLOTS*HS_W-1:0]  hs_to_slot_o,
    input logic [NUM_SLOTS*HS_W-1:0]  hs_to_static_i,
    input logic [NUM_SLOTS*HS_W-1:0]  hs_to_static_o,
    input logic [NUM_SLOTS*IRQ_W-1:0] irq_slot_i,
    input logic [NUM_SLOTS*IRQ_W-1:0] irq_static_o
);

    AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (rst)
        csr_bvalid |-> csr_bresp == 2'b00); // R11
    AST_RRESP_OKAY: assert property (@(posedge clk) disable iff (rst)
        csr_rvalid |-> csr_rresp == 2'b00); // R11
    AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        csr_bvalid && !csr_bready |=> csr_bvalid); // R11

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        AST_HS_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            slot_decouple[g] |-> (hs_to_slot_o[g*HS_W +: HS_W] == '0) &&
                                 (hs_to_static_o[g*HS_W +: HS_W] == '0)); // R7
        AST_HS_PASS: assert property (@(posedge clk) disable iff (rst)
            !slot_decouple[g] |-> (hs_to_slot_o[g*HS_W +: HS_W] == hs_to_slot_i[g*HS_W +: HS_W]) &&
                                  (hs_to_static_o[g*HS_W +: HS_W] == hs_to_static_i[g*HS_W +: HS_W])); // R7
        AST_IRQ_ISOLATED: assert property (@(posedge clk) disable iff (rst)
            slot_decouple[g] |-> irq_static_o[g*IRQ_W +: IRQ_W] == '0); // R8
        AST_IRQ_PASS: assert property (@(posedge clk) disable iff (rst)
            !slot_decouple[g] |-> irq_static_o[g*IRQ_W +: IRQ_W] == irq_slot_i[g*IRQ_W +: IRQ_W]); // R8
        AST_RST_HELD: assert property (@(posedge clk) disable iff (rst)
            slot_decouple[g] |-> !slot_rst_n[g]); // R4
        AST_CLK_ON_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
            $rose(slot_clk_en[g]) |-> $past(csr_awvalid && csr_wvalid)); // R3
    end

endmodule

bind slot_iso_mgr slot_iso_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .HS_W      (HS_W),
    .IRQ_W     (IRQ_W)
) u_chk (.*);

// File: tb/sim_slot_iso_mgr.sv
`timescale 1ns/1ps
module sim_slot_iso_mgr;

    localparam int NS  = 3;
    localparam int HW  = 10;
    localparam int IW  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [15:0] awaddr = '0;  logic awvalid = 0; logic awready;
    logic [31:0] wdata = '0;   logic wvalid = 0;  logic wready;
    logic [1:0]  bresp;        logic bvalid;      logic bready = 1'b1;
    logic [15:0] araddr = '0;  logic arvalid = 0; logic arready;
    logic [31:0] rdata;        logic [1:0] rresp; logic rvalid; logic rready = 1'b1;
    logic [NS-1:0] clk_en, dec, rst_n;
    logic [NS*4-1:0] axcache;
    logic [NS*3-1:0] axprot;
    logic [NS*HW-1:0] hs_sl_i = '0, hs_sl_o, hs_st_i = '0, hs_st_o;
    logic [NS*IW-1:0] irq_i = '0, irq_o;

    slot_iso_mgr #(.NUM_SLOTS(NS), .HS_W(HW), .IRQ_W(IW)) u0 (
        .clk(clk), .rst(rst),
        .csr_awaddr(awaddr), .csr_awvalid(awvalid), .csr_awready(awready),
        .csr_wdata(wdata), .csr_wvalid(wvalid), .csr_wready(wready),
        .csr_bresp(bresp), .csr_bvalid(bvalid), .csr_bready(bready),
        .csr_araddr(araddr), .csr_arvalid(arvalid), .csr_arready(arready),
        .csr_rdata(rdata), .csr_rresp(rresp), .csr_rvalid(rvalid), .csr_rready(rready),
        .slot_clk_en(clk_en), .slot_decouple(dec), .slot_rst_n(rst_n),
        .slot_axcache(axcache), .slot_axprot(axprot),
        .hs_to_slot_i(hs_sl_i), .hs_to_slot_o(hs_sl_o),
        .hs_to_static_i(hs_st_i), .hs_to_static_o(hs_st_o),
        .irq_slot_i(irq_i), .irq_static_o(irq_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Bench model of the register contents, built from the requirements.
    logic       m_run [NS];
    logic       m_rel [NS];
    logic [3:0] m_cache [NS];
    logic [2:0] m_prot [NS];

    logic [31:0] exp_q [$];
    string       tag_q [$];

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit mapped(input logic [15:0] a, output int s, output int r);
        int pg;
        pg = int'(a[15:12]);
        s  = pg - 4;
        r  = int'(a[3:2]);
        return (pg >= 4) && (pg < 4 + NS) && (a[11:4] == 8'h00) && (a[1:0] == 2'b00);
    endfunction

    function automatic logic [31:0] model_word(input logic [15:0] a);
        int s, r;
        if (!mapped(a, s, r)) return 32'h0;
        case (r)
            0: return {31'h0, m_run[s]};
            1: return {31'h0, m_rel[s]};
            2: return {28'h0, m_cache[s]};
            default: return {29'h0, m_prot[s]};
        endcase
    endfunction

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        int s, r;
        @(negedge clk);
        awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        check("R11 bvalid after write", 64'(bvalid), 64'd1);
        check("R11 bresp OKAY", 64'(bresp), 64'd0);
        if (mapped(a, s, r)) begin
            case (r)
                0: m_run[s]   = d[0];
                1: m_rel[s]   = d[0];
                2: m_cache[s] = d[3:0];
                default: m_prot[s] = d[2:0];
            endcase
        end
    endtask

    // Driver: pushes the expected read word, the monitor compares it.
    task automatic rd(input logic [15:0] a, input string req);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        exp_q.push_back(model_word(a));
        tag_q.push_back(req);
        @(negedge clk);
        arvalid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R11 unexpected read data actual=%0h expected=none", rdata);
            end else begin
                string t;
                logic [31:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                check(t, 64'(rdata), 64'(e));
                check("R11 rresp OKAY", 64'(rresp), 64'd0);
            end
        end
    end

    task automatic chk_outputs(input string req);
        logic [NS-1:0]    e_en, e_dec, e_rst;
        logic [NS*4-1:0]  e_c;
        logic [NS*3-1:0]  e_p;
        logic [NS*HW-1:0] e_hs1, e_hs2;
        logic [NS*IW-1:0] e_irq;
        for (int i = 0; i < NS; i++) begin
            e_en[i]  = m_run[i];
            e_dec[i] = !m_run[i];
            e_rst[i] = m_run[i] && m_rel[i];
            e_c[i*4 +: 4] = m_cache[i];
            e_p[i*3 +: 3] = m_prot[i];
            e_hs1[i*HW +: HW] = m_run[i] ? hs_sl_i[i*HW +: HW] : '0;
            e_hs2[i*HW +: HW] = m_run[i] ? hs_st_i[i*HW +: HW] : '0;
            e_irq[i*IW +: IW] = m_run[i] ? irq_i[i*IW +: IW] : '0;
        end
        check({req, " clk_en"}, 64'(clk_en), 64'(e_en));
        check({req, " decouple"}, 64'(dec), 64'(e_dec));
        check({req, " rst_n"}, 64'(rst_n), 64'(e_rst));
        check({req, " axcache"}, 64'(axcache), 64'(e_c));
        check({req, " axprot"}, 64'(axprot), 64'(e_p));
        check({req, " hs_to_slot"}, 64'(hs_sl_o), 64'(e_hs1));
        check({req, " hs_to_static"}, 64'(hs_st_o), 64'(e_hs2));
        check({req, " irq"}, 64'(irq_o), 64'(e_irq));
    endtask

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_run[i] = 0; m_rel[i] = 0; m_cache[i] = 0; m_prot[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, with all-ones on every crossing input (R7, R8)
        hs_sl_i = '1; hs_st_i = '1; irq_i = '1;
        #1;
        chk_outputs("R1 reset");
        for (int s = 0; s < NS; s++)
            for (int r = 0; r < 4; r++)
                rd(16'(16'h4000 + s*16'h1000 + r*4), "R1 reset readback");

        // R5 R6: attributes with all-ones data while isolated
        wr(16'h5008, 32'hFFFF_FFFF);
        wr(16'h500C, 32'hFFFF_FFFF);
        chk_outputs("R5 attributes while isolated");
        rd(16'h5008, "R6 cache mask");
        rd(16'h500C, "R6 prot mask");

        // R4: reset release ignored while isolated
        wr(16'h5004, 32'hFFFF_FFFF);
        chk_outputs("R4 release while isolated");
        rd(16'h5004, "R6 release mask");

        // R3 R10: couple slot 2, others stay isolated
        hs_sl_i = 30'h2AA_5A5C3; hs_st_i = 30'h15A_3C96E; irq_i = 12'hA5C;
        wr(16'h5000, 32'h0000_0003);
        chk_outputs("R3 R10 slot 2 coupled");
        rd(16'h5000, "R6 run mask");
        hs_sl_i = '1; hs_st_i = '1; irq_i = '1;
        #1;
        chk_outputs("R7 R8 all-ones coupled");

        // R9: unmapped accesses
        wr(16'h7000, 32'h1);
        wr(16'h4010, 32'hF);
        wr(16'h3000, 32'h1);
        wr(16'h6002, 32'h1);
        chk_outputs("R9 unmapped writes");
        rd(16'h7000, "R9 read above slots");
        rd(16'h3000, "R9 read below windows");
        rd(16'h5010, "R9 read unused offset");

        // R2: slot 3 window
        wr(16'h6008, 32'h6);
        wr(16'h6000, 32'h1);
        chk_outputs("R2 slot 3 window");
        rd(16'h6008, "R2 slot 3 cache");

        // R3 R4: isolate slot 2 again; release bit kept but reset reasserted
        wr(16'h5000, 32'h0);
        chk_outputs("R3 R4 slot 2 isolated again");
        rd(16'h5004, "R4 release kept");

        // R11: bvalid held while bready low
        @(negedge clk);
        bready = 1'b0;
        awaddr = 16'h400C; wdata = 32'h5; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        m_prot[0] = 3'd5;
        @(negedge clk);
        check("R11 bvalid held", 64'(bvalid), 64'd1);
        bready = 1'b1;
        @(negedge clk);
        check("R11 bvalid cleared", 64'(bvalid), 64'd0);
        chk_outputs("R5 prot slot 1");

        repeat (4) @(negedge clk);
        check("R11 all reads answered", 64'(exp_q.size()), 64'd0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule